// File: doc/BRIEF.md
# Fractional Clock Pattern Generator

The block derives a serial clock from a fast base clock. Each enabled base-clock cycle is one tick, and the output holds a level for a whole number of ticks. The output is built from "states". Within a state the level is constant, and the level flips at every state boundary. A pattern has two phases. The short phase has C−B states that are A ticks wide. The long phase has B+1 states that are A+1 ticks wide. The pattern then repeats. Mixing the two state widths gives an average output rate of base/(A+(B+1)/(C+1)). That rate always falls between base/(A+1) and base/A.

Software, or a neighbouring block, writes a 32-bit control word through a load strobe. The word is held as pending and is copied into the active settings only when the current pattern finishes. This means a partial pattern never appears on the output. A one-cycle wrap pulse marks the first tick of every new pattern.

Top module: `fracclk_gen`

## Requirements
- R1: A synchronous reset sets clkOut to 1 and wrapPulse to 0. It discards any pending word, reloads the default word (A=2, B=2, C=7), and restarts at the first state of the short phase.
- R2: A is taken from ctrlWord bits 31:22, B from bits 21:12 and C from bits 11:0. When C>B and A>0, each pattern opens with C−B states, each holding its level for A ticks.
- R3: After the short phase come B+1 states, each holding its level for A+1 ticks.
- R4: The level flips at every state boundary, including the boundary where one pattern ends and the next begins. No level is forced at a pattern start.
- R5: With A=2, B=2, C=7 the output from reset reads 1100110011000111000 and then repeats with alternation continuing.
- R6: One pattern lasts (C−B)·A+(B+1)·(A+1) ticks (with C−B taken as 0 when the short phase is skipped), measured between wrap pulses.
- R7: A word loaded with loadStrobe changes nothing until the end of the pattern in progress. A word loaded in the same cycle as a wrap waits for the following wrap.
- R8: When C≤B, or when A=0, the short phase is skipped and the pattern consists of the long phase alone.
- R9: While en is 0, no tick advances: clkOut, the position in the pattern and wrapPulse's source stay frozen, and wrapPulse is 0.
- R10: wrapPulse is 1 for exactly the cycle in which the first tick of a new pattern is shown after an enabled clock edge. It is never 1 for the pattern that starts out of reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock; each cycle with en=1 is one tick |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Tick enable |
| loadStrobe | input | 1 | Captures ctrlWord as the pending setting |
| ctrlWord | input | 32 | Control word {A, B, C} |
| clkOut | output | 1 | Generated clock level |
| wrapPulse | output | 1 | One-cycle marker of a new pattern's first tick |

## Verification
clkOut and wrapPulse both come from registers. A clock edge taken with en=1 therefore shows its result in the cycle right after that edge, and a load appears only through the pattern that begins after the next wrap. The bench keeps a queue of expected tick levels, each with a wrap flag. The queue is computed from the field formulas. On every falling edge the bench compares the head of the queue and pops it only if en is about to be sampled high. The wrap flag is compared only when the previous edge had en=1, so cycles that are held by en=0 are checked to be frozen with wrapPulse at 0.

// File: rtl/fracclk_pkg.sv
package fracclk_pkg;

  // Per-cycle strobes from the sequencer to the datapath
  typedef struct packed {
    logic tickInc;
    logic tickClr;
    logic stateInc;
    logic stateClr;
    logic enterLong;
    logic enterShort;
    logic toggle;
    logic commit;
  } stepCtl_t;

endpackage

// File: rtl/fracclk_datapath.sv
module fracclk_datapath
  import fracclk_pkg::*;
#(
  parameter int A_W = 10,
  parameter int B_W = 10,
  parameter int C_W = 12,
  parameter logic [A_W+B_W+C_W-1:0] RST_WORD = {10'd2, 10'd2, 12'd7}
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   loadStrobe,
  input  logic [A_W+B_W+C_W-1:0] ctrlWord,
  input  stepCtl_t               ctl,
  output logic [A_W-1:0]         actA,
  output logic [B_W-1:0]         actB,
  output logic [C_W-1:0]         actC,
  output logic [A_W-1:0]         pendA,
  output logic [B_W-1:0]         pendB,
  output logic [C_W-1:0]         pendC,
  output logic [A_W:0]           tickCnt,
  output logic [C_W-1:0]         stateCnt,
  output logic                   inLong,
  output logic                   clkOut,
  output logic                   wrapPulse
);

  localparam int W = A_W + B_W + C_W;
  localparam logic [A_W-1:0] RA = RST_WORD[W-1 -: A_W];
  localparam logic [B_W-1:0] RB = RST_WORD[C_W +: B_W];
  localparam logic [C_W-1:0] RC = RST_WORD[C_W-1:0];
  localparam logic RSKIP = (RC <= C_W'(RB)) || (RA == '0);

  logic [W-1:0] pendWord;

  assign pendA = pendWord[W-1 -: A_W];
  assign pendB = pendWord[C_W +: B_W];
  assign pendC = pendWord[C_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      pendWord  <= RST_WORD;
      actA      <= RA;
      actB      <= RB;
      actC      <= RC;
      tickCnt   <= '0;
      stateCnt  <= '0;
      inLong    <= RSKIP;
      clkOut    <= 1'b1;
      wrapPulse <= 1'b0;
    end else begin
      if (loadStrobe) pendWord <= ctrlWord;
      if (ctl.commit) begin
        actA <= pendA;
        actB <= pendB;
        actC <= pendC;
      end
      if (ctl.tickClr)      tickCnt <= '0;
      else if (ctl.tickInc) tickCnt <= tickCnt + 1'b1;
      if (ctl.stateClr)      stateCnt <= '0;
      else if (ctl.stateInc) stateCnt <= stateCnt + 1'b1;
      if (ctl.enterLong)       inLong <= 1'b1;
      else if (ctl.enterShort) inLong <= 1'b0;
      if (ctl.toggle) clkOut <= ~clkOut;
      wrapPulse <= ctl.commit;
    end
  end

  // R7: active settings move only on a pattern wrap
  p_cfg_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !ctl.commit |=> ($stable(actA) && $stable(actB) && $stable(actC)));

  // R4: a new pattern starts with a level flip
  p_wrap_toggles_r4: assert property (@(posedge clk) disable iff (rst)
    wrapPulse |-> (clkOut != $past(clkOut)));

  // R10: the wrap marker coincides with the pattern origin
  p_wrap_origin_r10: assert property (@(posedge clk) disable iff (rst)
    wrapPulse |-> (tickCnt == '0 && stateCnt == '0));

endmodule

// File: rtl/fracclk_control.sv
module fracclk_control
  import fracclk_pkg::*;
#(
  parameter int A_W = 10,
  parameter int B_W = 10,
  parameter int C_W = 12
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           en,
  input  logic [A_W-1:0] actA,
  input  logic [B_W-1:0] actB,
  input  logic [C_W-1:0] actC,
  input  logic [A_W-1:0] pendA,
  input  logic [B_W-1:0] pendB,
  input  logic [C_W-1:0] pendC,
  input  logic [A_W:0]   tickCnt,
  input  logic [C_W-1:0] stateCnt,
  input  logic           inLong,
  output stepCtl_t       ctl
);

  logic [C_W-1:0] shortCount;
  logic [A_W:0]   stateLen;
  logic           lastTick;
  logic           lastState;
  logic           pendSkip;

  always_comb begin
    shortCount = (actC > C_W'(actB)) ? (actC - C_W'(actB)) : '0;
    stateLen   = inLong ? ({1'b0, actA} + 1'b1) : {1'b0, actA};
    lastTick   = (tickCnt == stateLen - 1'b1);
    lastState  = inLong ? (stateCnt == C_W'(actB)) : (stateCnt == shortCount - 1'b1);
    pendSkip   = (pendC <= C_W'(pendB)) || (pendA == '0);
  end

  always_comb begin
    ctl = '0;
    if (en) begin
      if (!lastTick) begin
        ctl.tickInc = 1'b1;
      end else begin
        ctl.tickClr = 1'b1;
        ctl.toggle  = 1'b1;
        if (!lastState) begin
          ctl.stateInc = 1'b1;
        end else begin
          ctl.stateClr = 1'b1;
          if (!inLong) begin
            ctl.enterLong = 1'b1;
          end else begin
            ctl.commit = 1'b1;
            if (pendSkip) ctl.enterLong  = 1'b1;
            else          ctl.enterShort = 1'b1;
          end
        end
      end
    end
  end

  // R2/R3: tick position never runs past the current state width
  p_tick_bound_r2: assert property (@(posedge clk) disable iff (rst)
    tickCnt < stateLen);

  // R8: short phase is only ever entered with a non-empty state count
  p_short_state_bound_r8: assert property (@(posedge clk) disable iff (rst)
    !inLong |-> (stateCnt < shortCount));

  // R9: no movement while ticks are disabled
  p_idle_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !en |=> ($stable(tickCnt) && $stable(stateCnt) && $stable(inLong)));

endmodule

// File: rtl/fracclk_gen.sv
module fracclk_gen
  import fracclk_pkg::*;
#(
  parameter int A_W = 10,
  parameter int B_W = 10,
  parameter int C_W = 12,
  parameter logic [A_W+B_W+C_W-1:0] RST_WORD = {10'd2, 10'd2, 12'd7}
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   en,
  input  logic                   loadStrobe,
  input  logic [A_W+B_W+C_W-1:0] ctrlWord,
  output logic                   clkOut,
  output logic                   wrapPulse
);

  stepCtl_t       ctl;
  logic [A_W-1:0] actA, pendA;
  logic [B_W-1:0] actB, pendB;
  logic [C_W-1:0] actC, pendC;
  logic [A_W:0]   tickCnt;
  logic [C_W-1:0] stateCnt;
  logic           inLong;

  fracclk_control #(.A_W(A_W), .B_W(B_W), .C_W(C_W)) u_ctrl (
    .clk(clk), .rst(rst), .en(en),
    .actA(actA), .actB(actB), .actC(actC),
    .pendA(pendA), .pendB(pendB), .pendC(pendC),
    .tickCnt(tickCnt), .stateCnt(stateCnt), .inLong(inLong),
    .ctl(ctl)
  );

  fracclk_datapath #(.A_W(A_W), .B_W(B_W), .C_W(C_W), .RST_WORD(RST_WORD)) u_dp (
    .clk(clk), .rst(rst), .loadStrobe(loadStrobe), .ctrlWord(ctrlWord), .ctl(ctl),
    .actA(actA), .actB(actB), .actC(actC),
    .pendA(pendA), .pendB(pendB), .pendC(pendC),
    .tickCnt(tickCnt), .stateCnt(stateCnt), .inLong(inLong),
    .clkOut(clkOut), .wrapPulse(wrapPulse)
  );

endmodule

// File: tb/fracclk_gen_tb.sv
module fracclk_gen_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        en = 1'b0;
  logic        loadStrobe = 1'b0;
  logic [31:0] ctrlWord = '0;
  logic        clkOut;
  logic        wrapPulse;

  always #2 clk = ~clk;  // 250 MHz

  fracclk_gen u_dut (
    .clk(clk), .rst(rst), .en(en), .loadStrobe(loadStrobe),
    .ctrlWord(ctrlWord), .clkOut(clkOut), .wrapPulse(wrapPulse)
  );

  typedef struct {
    bit    lvl;
    bit    wrap;
    string tag;
  } expItem_t;

  expItem_t q[$];
  int  checks = 0;
  int  failures = 0;
  bit  expLvl = 1'b1;
  bit  armed = 1'b0;
  bit  prevEn = 1'b0;

  function automatic logic [31:0] mkWord(int a, int b, int c);
    return {a[9:0], b[9:0], c[11:0]};
  endfunction

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // Expected pattern from the field formulas (short phase, then long phase)
  function automatic void pushPattern(int a, int b, int c, bit wrapFirst, string tag);
    int  shortN;
    bit  first;
    expItem_t it;
    shortN = (c > b && a > 0) ? (c - b) : 0;
    first = 1'b1;
    for (int s = 0; s < shortN; s++) begin
      for (int t = 0; t < a; t++) begin
        it.lvl = expLvl; it.wrap = first & wrapFirst; it.tag = tag;
        q.push_back(it); first = 1'b0;
      end
      expLvl = ~expLvl;
    end
    for (int s = 0; s < b + 1; s++) begin
      for (int t = 0; t < a + 1; t++) begin
        it.lvl = expLvl; it.wrap = first & wrapFirst; it.tag = (shortN > 0) ? "R3" : tag;
        q.push_back(it); first = 1'b0;
      end
      expLvl = ~expLvl;
    end
  endfunction

  // Monitor: compare at the falling edge, pop when the next edge will tick
  always @(negedge clk) begin
    if (armed) begin
      if (q.size() > 0) begin
        expItem_t it;
        it = q[0];
        chk(clkOut == it.lvl, it.tag, "clkOut", int'(clkOut), int'(it.lvl));
        chk(wrapPulse == (it.wrap && prevEn), it.wrap ? "R6" : "R10", "wrapPulse",
            int'(wrapPulse), int'(it.wrap && prevEn));
        if (en) void'(q.pop_front());
      end
      prevEn = en;
    end
  end

  // Driver: run until every queued tick has been shown; gateMod>0 idles one cycle in gateMod
  task automatic runSeg(int gateMod, int loadAt, logic [31:0] word);
    int i = 0;
    while (1) begin
      @(posedge clk); #1;
      if (q.size() == 0) begin
        en = 1'b0; loadStrobe = 1'b0;
        break;
      end
      en = (gateMod == 0) ? 1'b1 : ((i % gateMod) != (gateMod - 1));
      loadStrobe = (i == loadAt);
      ctrlWord = word;
      i++;
    end
  endtask

  task automatic doReset(string tag);
    armed = 1'b0;
    @(posedge clk); #1;
    rst = 1'b1; en = 1'b0; loadStrobe = 1'b0;
    repeat (2) @(posedge clk);
    #1;
    chk(clkOut == 1'b1, tag, "reset clkOut", int'(clkOut), 1);
    chk(wrapPulse == 1'b0, tag, "reset wrapPulse", int'(wrapPulse), 0);
    q.delete();
    expLvl = 1'b1;
    rst = 1'b0;
    prevEn = 1'b0;
    armed = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    // R1 reset state, R5 worked example, R4 alternation across the wrap
    doReset("R1");
    pushPattern(2, 2, 7, 1'b0, "R5");
    pushPattern(2, 2, 7, 1'b1, "R4");
    runSeg(0, -1, '0);

    // R7: word loaded mid-pattern waits for the wrap; R2 new short phase
    pushPattern(2, 2, 7, 1'b1, "R7");
    pushPattern(3, 1, 4, 1'b1, "R7");
    pushPattern(3, 1, 4, 1'b1, "R2");
    runSeg(0, 4, mkWord(3, 1, 4));

    // R9: ticks gated by en, output frozen while idle
    pushPattern(3, 1, 4, 1'b1, "R9");
    pushPattern(3, 1, 4, 1'b1, "R9");
    runSeg(3, -1, mkWord(3, 1, 4));

    // R8: C<=B skips the short phase
    pushPattern(3, 1, 4, 1'b1, "R7");
    pushPattern(3, 4, 2, 1'b1, "R8");
    pushPattern(3, 4, 2, 1'b1, "R8");
    runSeg(0, 0, mkWord(3, 4, 2));

    // R2/R3: one-tick short states, two-tick long state
    pushPattern(3, 4, 2, 1'b1, "R8");
    pushPattern(1, 0, 5, 1'b1, "R2");
    pushPattern(1, 0, 5, 1'b1, "R6");
    runSeg(0, 3, mkWord(1, 0, 5));

    // R1: pending word discarded by reset, default pattern resumes
    @(posedge clk); #1;
    ctrlWord = mkWord(5, 0, 9); loadStrobe = 1'b1;
    @(posedge clk); #1;
    loadStrobe = 1'b0;
    doReset("R1");
    pushPattern(2, 2, 7, 1'b0, "R1");
    pushPattern(2, 2, 7, 1'b1, "R1");
    runSeg(0, -1, '0);

    repeat (2) @(posedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule